// File: doc/BRIEF.md
# Two-Register Datapath with Swap and Clear Decoding

This block is a very small processor datapath. It holds two 2-bit registers, called slot 0 and slot 1. Each register sits behind its own four-way source selector. The selector takes slot 0, slot 1, an immediate operand or the output of a small adder. A per-register enable decides whether the register takes the selected value on the clock edge or keeps its old one. An instruction decoder turns each 8-bit instruction into the two selector controls.

Each register has its own selector, so both registers can be written in the same cycle. A swap of the two slots therefore completes in one clock, with no temporary storage. A clear of both slots also takes one clock. The other operations are: load an immediate into one slot, write the modular sum of the two slots into one slot, and do nothing.

Each control is a 3-bit bundle. The enable is in bit 0 and the source code is in bits 2:1. The source codes are 00 for slot 0, 01 for slot 1, 10 for the immediate and 11 for the adder. A clear works by enabling both selectors on the immediate source while the immediate is forced to 00.

Top module: `dp2_core`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, both registers become 00 on that edge, whatever the instruction is.
- R2: For the load and add operations, the slot not named by instruction bit 4 keeps its value across the edge.
- R3: Opcode `instr[7:5]` = 000 loads `imm` into the slot named by `instr[4]` (0 is slot 0, 1 is slot 1).
- R4: Opcode 001 writes (slot 0 + slot 1) mod 4, taken from the values before the edge, into the slot named by `instr[4]`.
- R5: Opcode 101 swaps the two slots in one clock. `instr[4:0]` and `imm` have no effect on the result.
- R6: Opcode 110 writes 00 into both slots in one clock, even when `imm` is nonzero. `instr[4:0]` has no effect.
- R7: Opcodes 010, 011, 100 and 111 leave both slots unchanged, whatever `imm` and `instr[4:0]` are.
- R8: Register outputs change only on a rising clock edge. The new value is visible from that edge until the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 8 | Instruction; bits 7:5 opcode, bit 4 destination |
| imm | input | 2 | Immediate operand |
| r0_q | output | 2 | Current value of slot 0 |
| r1_q | output | 2 | Current value of slot 1 |

## Verification
The hardest cases to reach depend on register contents that only an earlier instruction can create. One is a swap of two different nonzero values. Another is an add whose sum wraps past 3. A third is a clear while the immediate input holds a nonzero value. The stimulus first builds these states with directed loads: slot 0 = 3 and slot 1 = 1, then add, then swap, then clear with `imm` = 3 and junk in the low instruction bits. After that, a long pseudo-random run interleaves every opcode, and a mid-run reset is applied while both slots hold nonzero values.

// File: rtl/dp2_pkg.sv
package dp2_pkg;

   // Source selector codes (bits 2:1 of a control bundle)
   localparam logic [1:0] SRC_SLOT0 = 2'b00;
   localparam logic [1:0] SRC_SLOT1 = 2'b01;
   localparam logic [1:0] SRC_IMM   = 2'b10;
   localparam logic [1:0] SRC_ADDER = 2'b11;

   // Opcodes carried in the top three instruction bits
   localparam logic [2:0] OP_LOAD  = 3'b000;
   localparam logic [2:0] OP_SUM   = 3'b001;
   localparam logic [2:0] OP_SWAP  = 3'b101;
   localparam logic [2:0] OP_CLEAR = 3'b110;

   localparam int OPC_W   = 3;
   localparam int NSLOT   = 2;
   localparam int NSRC    = 4;
   localparam int SRCSEL_W = $clog2(NSRC);

   // Control bundle: {sel[1:0], en} -> enable is bit 0, select is bits 2:1
   typedef struct packed {
      logic [SRCSEL_W-1:0] sel;
      logic                en;
   } slot_ctl_t;

endpackage

// File: rtl/dp2_adder.sv
module dp2_adder #(
   parameter int DATA_W   = 2,
   parameter bit RIPPLE   = 1'b0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] sum
);

   initial begin
      assert (DATA_W >= 1) else $fatal(1, "dp2_adder: DATA_W must be at least 1");
   end

   generate
      if (RIPPLE) begin : g_ripple
         logic [DATA_W:0] carry;
         assign carry[0] = 1'b0;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]     = a[i] ^ b[i] ^ carry[i];
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
         end
      end else begin : g_behav
         // Carry out discarded: result is modulo 2**DATA_W
         assign sum = a + b;
      end
   endgenerate

endmodule

// File: rtl/dp2_decoder.sv
module dp2_decoder
   import dp2_pkg::*;
#(
   parameter int INSTR_W  = 8,
   parameter int DEST_BIT = INSTR_W - OPC_W - 1
) (
   input  logic [INSTR_W-1:0]  instr,
   output slot_ctl_t [NSLOT-1:0] ctl,
   output logic                imm_zero
);

   localparam int OPC_LSB = INSTR_W - OPC_W;

   initial begin
      assert (INSTR_W > OPC_W) else $fatal(1, "dp2_decoder: INSTR_W too small");
      assert (DEST_BIT < OPC_LSB && DEST_BIT >= 0)
         else $fatal(1, "dp2_decoder: DEST_BIT overlaps opcode");
   end

   logic [OPC_W-1:0] opc;
   logic             dest;

   assign opc  = instr[INSTR_W-1:OPC_LSB];
   assign dest = instr[DEST_BIT];

   always_comb begin
      for (int s = 0; s < NSLOT; s++) begin
         ctl[s].sel = SRC_SLOT0;
         ctl[s].en  = 1'b0;
      end
      imm_zero = 1'b0;
      case (opc)
         OP_LOAD: begin
            ctl[dest].sel = SRC_IMM;
            ctl[dest].en  = 1'b1;
         end
         OP_SUM: begin
            ctl[dest].sel = SRC_ADDER;
            ctl[dest].en  = 1'b1;
         end
         OP_SWAP: begin
            ctl[0].sel = SRC_SLOT1;
            ctl[0].en  = 1'b1;
            ctl[1].sel = SRC_SLOT0;
            ctl[1].en  = 1'b1;
         end
         OP_CLEAR: begin
            ctl[0].sel = SRC_IMM;
            ctl[0].en  = 1'b1;
            ctl[1].sel = SRC_IMM;
            ctl[1].en  = 1'b1;
            imm_zero   = 1'b1;
         end
         default: begin
            // no operation: both enables stay low
         end
      endcase
   end

endmodule

// File: rtl/dp2_slot.sv
module dp2_slot
   import dp2_pkg::*;
#(
   parameter int DATA_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  slot_ctl_t         ctl,
   input  logic [DATA_W-1:0] src_slot0,
   input  logic [DATA_W-1:0] src_slot1,
   input  logic [DATA_W-1:0] src_imm,
   input  logic [DATA_W-1:0] src_adder,
   output logic [DATA_W-1:0] q
);

   logic [DATA_W-1:0] d;

   always_comb begin
      case (ctl.sel)
         SRC_SLOT0: d = src_slot0;
         SRC_SLOT1: d = src_slot1;
         SRC_IMM:   d = src_imm;
         default:   d = src_adder;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (ctl.en)
         q <= d;
   end

endmodule

// File: rtl/dp2_core.sv
module dp2_core
   import dp2_pkg::*;
#(
   parameter int DATA_W     = 2,
   parameter int INSTR_W    = 8,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] instr,
   input  logic [DATA_W-1:0]  imm,
   output logic [DATA_W-1:0]  r0_q,
   output logic [DATA_W-1:0]  r1_q
);

   localparam int DEST_BIT = INSTR_W - OPC_W - 1;

   initial begin
      assert (DATA_W >= 1) else $fatal(1, "dp2_core: DATA_W must be at least 1");
      assert (INSTR_W >= OPC_W + 1) else $fatal(1, "dp2_core: INSTR_W too small");
   end

   slot_ctl_t [NSLOT-1:0] ctl;
   logic                  imm_zero;
   logic [DATA_W-1:0]     imm_eff;
   logic [DATA_W-1:0]     adder_out;
   logic [DATA_W-1:0]     slot_q [NSLOT];

   dp2_decoder #(
      .INSTR_W  (INSTR_W),
      .DEST_BIT (DEST_BIT)
   ) u_dec (
      .instr    (instr),
      .ctl      (ctl),
      .imm_zero (imm_zero)
   );

   dp2_adder #(
      .DATA_W (DATA_W),
      .RIPPLE (RIPPLE_ADD)
   ) u_add (
      .a   (slot_q[0]),
      .b   (slot_q[1]),
      .sum (adder_out)
   );

   assign imm_eff = imm_zero ? '0 : imm;

   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         dp2_slot #(
            .DATA_W (DATA_W)
         ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .ctl       (ctl[s]),
            .src_slot0 (slot_q[0]),
            .src_slot1 (slot_q[1]),
            .src_imm   (imm_eff),
            .src_adder (adder_out),
            .q         (slot_q[s])
         );
      end
   endgenerate

   assign r0_q = slot_q[0];
   assign r1_q = slot_q[1];

endmodule

// File: rtl/dp2_core_chk.sv
module dp2_core_chk #(
   parameter int DATA_W  = 2,
   parameter int INSTR_W = 8
) (
   input logic               clk,
   input logic               rst,
   input logic [INSTR_W-1:0] instr,
   input logic [DATA_W-1:0]  imm,
   input logic [DATA_W-1:0]  r0_q,
   input logic [DATA_W-1:0]  r1_q
);

   logic [2:0] opc;
   logic       dest;
   assign opc  = instr[INSTR_W-1:INSTR_W-3];
   assign dest = instr[INSTR_W-4];

   // R1: reset clears both slots on the next edge
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (r0_q == '0 && r1_q == '0));

   // R3 / R2: load into one slot, other slot holds
   a_r3_load_slot0: assert property (@(posedge clk) disable iff (rst)
      (opc == 3'b000 && !dest) |=> (r0_q == $past(imm) && r1_q == $past(r1_q)));
   a_r3_load_slot1: assert property (@(posedge clk) disable iff (rst)
      (opc == 3'b000 && dest) |=> (r1_q == $past(imm) && r0_q == $past(r0_q)));

   // R4 / R2: modular sum into one slot
   a_r4_sum_slot0: assert property (@(posedge clk) disable iff (rst)
      (opc == 3'b001 && !dest) |=>
         (r0_q == DATA_W'($past(r0_q) + $past(r1_q)) && r1_q == $past(r1_q)));
   a_r4_sum_slot1: assert property (@(posedge clk) disable iff (rst)
      (opc == 3'b001 && dest) |=>
         (r1_q == DATA_W'($past(r0_q) + $past(r1_q)) && r0_q == $past(r0_q)));

   // R5: single-cycle swap
   a_r5_swap: assert property (@(posedge clk) disable iff (rst)
      (opc == 3'b101) |=> (r0_q == $past(r1_q) && r1_q == $past(r0_q)));

   // R6: dual clear regardless of immediate
   a_r6_clear: assert property (@(posedge clk) disable iff (rst)
      (opc == 3'b110) |=> (r0_q == '0 && r1_q == '0));

   // R7: unused opcodes hold both slots
   a_r7_noop_hold: assert property (@(posedge clk) disable iff (rst)
      (opc inside {3'b010, 3'b011, 3'b100, 3'b111}) |=> ($stable(r0_q) && $stable(r1_q)));

endmodule

bind dp2_core dp2_core_chk #(
   .DATA_W  (DATA_W),
   .INSTR_W (INSTR_W)
) u_chk (
   .clk   (clk),
   .rst   (rst),
   .instr (instr),
   .imm   (imm),
   .r0_q  (r0_q),
   .r1_q  (r1_q)
);

// File: tb/dp2_core_tb.sv
module dp2_core_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] instr = 8'h40;
   logic [1:0] imm = 2'b00;
   logic [1:0] r0_q, r1_q;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // reference model state
   int m0 = 0;
   int m1 = 0;

   always #5 clk = ~clk;

   dp2_core u_dut (
      .clk   (clk),
      .rst   (rst),
      .instr (instr),
      .imm   (imm),
      .r0_q  (r0_q),
      .r1_q  (r1_q)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Called at a falling edge: drive, advance model, compare at next falling edge
   task automatic step(input logic r, input logic [7:0] ins, input logic [1:0] im);
      int opc, dst, n0, n1;
      string t0, t1;
      rst = r; instr = ins; imm = im;
      opc = ins[7:5]; dst = ins[4];
      n0 = m0; n1 = m1;
      if (r) begin
         n0 = 0; n1 = 0; t0 = "R1"; t1 = "R1";
      end else begin
         case (opc)
            0: begin
               if (dst == 0) begin n0 = im; t0 = "R3"; t1 = "R2"; end
               else          begin n1 = im; t1 = "R3"; t0 = "R2"; end
            end
            1: begin
               if (dst == 0) begin n0 = (m0 + m1) % 4; t0 = "R4"; t1 = "R2"; end
               else          begin n1 = (m0 + m1) % 4; t1 = "R4"; t0 = "R2"; end
            end
            5: begin n0 = m1; n1 = m0; t0 = "R5"; t1 = "R5"; end
            6: begin n0 = 0; n1 = 0; t0 = "R6"; t1 = "R6"; end
            default: begin t0 = "R7"; t1 = "R7"; end
         endcase
      end
      // R8: before the edge the outputs still show the old state
      @(posedge clk);
      #1;
      m0 = n0; m1 = n1;
      @(negedge clk);
      check(t0, "slot0", int'(r0_q), m0);
      check(t1, "slot1", int'(r1_q), m1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] lfsr;
      @(negedge clk);
      step(1'b1, 8'h40, 2'b11);
      step(1'b1, 8'hA0, 2'b10);   // R1: reset wins over a swap
      // R8: mid-cycle the outputs hold the reset value
      check("R8", "slot0 stable between edges", int'(r0_q), 0);
      step(1'b0, 8'h00, 2'b11);   // R3: slot0 <= 3
      step(1'b0, 8'h10, 2'b01);   // R3: slot1 <= 1
      // R8: outputs unchanged away from the edge
      #2;
      check("R8", "slot1 between edges", int'(r1_q), 1);
      step(1'b0, 8'h20, 2'b10);   // R4: wrap 3+1 -> 0 into slot0
      step(1'b0, 8'h00, 2'b10);   // slot0 <= 2
      step(1'b0, 8'h30, 2'b00);   // R4: slot1 <= 2+1 = 3
      step(1'b0, 8'hBF, 2'b11);   // R5: swap with junk low bits
      step(1'b0, 8'hA0, 2'b00);   // R5: swap back
      step(1'b0, 8'h5A, 2'b11);   // R7: noop 010
      step(1'b0, 8'h7F, 2'b10);   // R7: noop 011
      step(1'b0, 8'h95, 2'b01);   // R7: noop 100
      step(1'b0, 8'hE3, 2'b11);   // R7: noop 111
      step(1'b0, 8'hDF, 2'b11);   // R6: clear with imm 3
      step(1'b0, 8'h00, 2'b01);
      step(1'b0, 8'h10, 2'b10);
      step(1'b0, 8'hC0, 2'b10);   // R6: clear again
      lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step((i == 300), lfsr[7:0], lfsr[9:8]);
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule